// File: doc/BRIEF.md
# Character-Clock Raster Timing Generator

This block produces the horizontal and vertical sync, the blanking signal and the display-enable for a raster display. It runs on the character clock, one tick for every eight pixels. Horizontal positions are counted in characters and vertical positions in scan lines. Software programs the timing through a bank of indexed 8-bit registers. It writes an index byte with one strobe and then a data byte with another. Vertical quantities are 11 bits wide, so their upper bits sit in overflow registers. A separate output-control byte selects the sync polarities.

Several stored values are biased. The line length is stored minus five. The frame length is stored minus two. Both display ends and the vertical blank start are stored minus one. Each sync end is stored only as a few low bits, and the sync ends when the counter's low bits match them. The block decodes the register bank into a working copy. It loads that copy only when a frame ends, so a frame never mixes old and new timing. Double scan repeats every line twice. In interlaced mode software programs the vertical values at half size, except the display end, which the block halves itself. A field flag toggles at the end of every field.

Top module: `crtc_timing_gen`

## Requirements
- R1: A pulse on `idxWr` stores `wrByte` as the current index. A pulse on `dataWr` writes `wrByte` into the register at that index. Indices at or above 64 are ignored.
- R2: While bit 7 of register 0x11 is set, data writes to indices 0x00 to 0x07 are ignored. Register 0x11 itself and all higher registers stay writable.
- R3: Register and output-control writes take effect only from the first character of the next frame, or of the next field when interlaced.
- R4: A line is (reg 0x00 + 5) characters long. Characters 0 to reg 0x01 are horizontally displayed. The remaining characters are horizontally blanked.
- R5: Horizontal sync is active from the character equal to reg 0x04. It stays active up to the character before the one whose low 5 bits equal reg 0x05[4:0], and this end may fall after the line wraps.
- R6: The 11-bit vertical fields are assembled as follows. Total uses bits 8, 9 and 10 from reg 0x07 bit 0, reg 0x07 bit 5 and reg 0x30 bit 3. Display end uses reg 0x07 bits 1 and 6 and reg 0x30 bit 2. Blank start uses reg 0x07 bit 3, reg 0x09 bit 5 and reg 0x30 bit 1. Sync start uses reg 0x07 bits 2 and 7 and reg 0x30 bit 0. The low bytes are regs 0x06, 0x12, 0x15 and 0x10.
- R7: A frame has (total + 2) lines. Lines 0 to display end are vertically displayed. Lines above the blank-start value are blanked until the frame wraps. `dispEn` is horizontal display AND vertical display. `blank` is horizontal blank OR vertical blank.
- R8: Vertical sync is active from the line equal to sync start. It stays active up to the line before the one whose low 4 bits equal reg 0x11[3:0].
- R9: Setting reg 0x09 bit 7 makes each line count twice, so every line lasts two line periods.
- R10: Setting reg 0x30 bit 7 enables interlace. Each field then runs the programmed vertical timing, the display end is compared at half value, and `field` toggles at every field end. With interlace off, `field` returns to 0.
- R11: In the output-control byte, bit 6 makes horizontal sync active-low and bit 7 makes vertical sync active-low. Like the timing registers, the change waits for the frame boundary.
- R12: After reset all registers are zero. This gives a 5-character line and a 2-line frame. At the first character, `hSync`=1, `vSync`=1, `dispEn`=1, `blank`=0 and `field`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Active-low synchronous reset |
| idxWr | input | 1 | Store `wrByte` as register index |
| dataWr | input | 1 | Write `wrByte` to the indexed register |
| miscWr | input | 1 | Write `wrByte` to the output-control byte |
| wrByte | input | 8 | Write data for all three strobes |
| hSync | output | 1 | Horizontal sync, polarity per R11 |
| vSync | output | 1 | Vertical sync, polarity per R11 |
| blank | output | 1 | Composite blanking |
| dispEn | output | 1 | Active display area |
| field | output | 1 | Interlace field flag |

## Verification
A register write and the frame-boundary reload can land on the same clock edge. The reload must copy the register value as it stood before that edge, and the new byte must wait for the next frame. The bench provokes this by issuing writes at arbitrary moments while the frame runs, including writes that coincide with a wrap. A cycle-level scoreboard model applies the same edge ordering, and any mismatch in sync, blank, display-enable or field shows up on the following cycles. A second coincidence is a sync whose end lies beyond the line or frame wrap. This is judged by comparing the sync outputs across the wrap.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int CHAR_W = 8;
  localparam int HCNT_W = 9;
  localparam int VFLD_W = 11;
  localparam int VCNT_W = VFLD_W + 1;
  localparam int HSE_W = 5;
  localparam int VSE_W = 4;
  localparam int HTOT_BIAS = 5;
  localparam int VTOT_BIAS = 2;
  localparam int LOCK_LIMIT = 8;
  localparam int LOCK_BIT = 7;

  localparam int IDX_HTOT = 'h00;
  localparam int IDX_HDE  = 'h01;
  localparam int IDX_HSS  = 'h04;
  localparam int IDX_HSE  = 'h05;
  localparam int IDX_VTOT = 'h06;
  localparam int IDX_OVF  = 'h07;
  localparam int IDX_DSC  = 'h09;
  localparam int IDX_VSS  = 'h10;
  localparam int IDX_VSE  = 'h11;
  localparam int IDX_VDE  = 'h12;
  localparam int IDX_VBS  = 'h15;
  localparam int IDX_EXT  = 'h30;

  typedef struct packed {
    logic [HCNT_W-1:0] hLast;
    logic [HCNT_W-1:0] hDeLast;
    logic [CHAR_W-1:0] hSyncStart;
    logic [HSE_W-1:0]  hSyncEnd;
    logic [VCNT_W-1:0] vLast;
    logic [VFLD_W-1:0] vDeLast;
    logic [VFLD_W-1:0] vBlankAfter;
    logic [VFLD_W-1:0] vSyncStart;
    logic [VSE_W-1:0]  vSyncEnd;
    logic              dblScan;
    logic              interlace;
    logic              hNeg;
    logic              vNeg;
  } crtc_timing_t;

  typedef struct packed {
    logic lineEnd;
    logic lineAdv;
    logic frameEnd;
  } crtc_strobe_t;
endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
#(
  parameter int REG_IDX_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idxWr,
  input  logic              dataWr,
  input  logic              miscWr,
  input  logic [CHAR_W-1:0] wrByte,
  input  crtc_strobe_t      strb,
  output crtc_timing_t      tim
);
  localparam int NREGS = 1 << REG_IDX_W;
  localparam logic [REG_IDX_W-1:0] I_HTOT = REG_IDX_W'(IDX_HTOT);
  localparam logic [REG_IDX_W-1:0] I_HDE  = REG_IDX_W'(IDX_HDE);
  localparam logic [REG_IDX_W-1:0] I_HSS  = REG_IDX_W'(IDX_HSS);
  localparam logic [REG_IDX_W-1:0] I_HSE  = REG_IDX_W'(IDX_HSE);
  localparam logic [REG_IDX_W-1:0] I_VTOT = REG_IDX_W'(IDX_VTOT);
  localparam logic [REG_IDX_W-1:0] I_OVF  = REG_IDX_W'(IDX_OVF);
  localparam logic [REG_IDX_W-1:0] I_DSC  = REG_IDX_W'(IDX_DSC);
  localparam logic [REG_IDX_W-1:0] I_VSS  = REG_IDX_W'(IDX_VSS);
  localparam logic [REG_IDX_W-1:0] I_VSE  = REG_IDX_W'(IDX_VSE);
  localparam logic [REG_IDX_W-1:0] I_VDE  = REG_IDX_W'(IDX_VDE);
  localparam logic [REG_IDX_W-1:0] I_VBS  = REG_IDX_W'(IDX_VBS);
  localparam logic [REG_IDX_W-1:0] I_EXT  = REG_IDX_W'(IDX_EXT);

  logic [CHAR_W-1:0] regs [NREGS];
  logic [CHAR_W-1:0] idxReg;
  logic [CHAR_W-1:0] miscReg;
  logic [REG_IDX_W-1:0] slot;
  logic inRange, locked, lowTarget, wrOk;
  logic [LOCK_LIMIT*CHAR_W-1:0] lowBank;
  logic [VFLD_W-1:0] vtotF;
  crtc_timing_t nxt;

  assign slot      = idxReg[REG_IDX_W-1:0];
  assign inRange   = (idxReg >> REG_IDX_W) == '0;
  assign locked    = regs[I_VSE][LOCK_BIT];
  assign lowTarget = idxReg < CHAR_W'(LOCK_LIMIT);
  assign wrOk      = dataWr && inRange && !(locked && lowTarget);

  for (genvar g = 0; g < LOCK_LIMIT; g++) begin : gLow
    assign lowBank[g*CHAR_W +: CHAR_W] = regs[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg  <= '0;
      miscReg <= '0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      if (idxWr) idxReg <= wrByte;
      if (miscWr) miscReg <= wrByte;
      if (wrOk) regs[slot] <= wrByte;
    end
  end

  // Decode the live bank into the timing view; vertical fields gather overflow bits.
  always_comb begin
    vtotF           = {regs[I_EXT][3], regs[I_OVF][5], regs[I_OVF][0], regs[I_VTOT]};
    nxt.hLast       = HCNT_W'(regs[I_HTOT]) + HCNT_W'(HTOT_BIAS - 1);
    nxt.hDeLast     = HCNT_W'(regs[I_HDE]);
    nxt.hSyncStart  = regs[I_HSS];
    nxt.hSyncEnd    = regs[I_HSE][HSE_W-1:0];
    nxt.vLast       = VCNT_W'(vtotF) + VCNT_W'(VTOT_BIAS - 1);
    nxt.vDeLast     = {regs[I_EXT][2], regs[I_OVF][6], regs[I_OVF][1], regs[I_VDE]};
    nxt.vBlankAfter = {regs[I_EXT][1], regs[I_DSC][5], regs[I_OVF][3], regs[I_VBS]};
    nxt.vSyncStart  = {regs[I_EXT][0], regs[I_OVF][7], regs[I_OVF][2], regs[I_VSS]};
    nxt.vSyncEnd    = regs[I_VSE][VSE_W-1:0];
    nxt.dblScan     = regs[I_DSC][7];
    nxt.interlace   = regs[I_EXT][7];
    nxt.hNeg        = miscReg[6];
    nxt.vNeg        = miscReg[7];
  end

  // Working copy reloads only at the frame boundary.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tim       <= '0;
      tim.hLast <= HCNT_W'(HTOT_BIAS - 1);
      tim.vLast <= VCNT_W'(VTOT_BIAS - 1);
    end else if (strb.frameEnd) begin
      tim <= nxt;
    end
  end

  // R2: a locked write to the low bank leaves it untouched
  p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && locked && lowTarget) |=> $stable(lowBank));

  // R3: timing view changes only after a frame boundary
  p_shadow_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.frameEnd |=> $stable(tim));
endmodule

// File: rtl/crtc_ctrl.sv
module crtc_ctrl
  import crtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  crtc_timing_t      tim,
  output crtc_strobe_t      strb,
  output logic [HCNT_W-1:0] hCnt,
  output logic [VCNT_W-1:0] vCnt,
  output logic              field
);
  logic scanRep;

  always_comb begin
    strb.lineEnd  = hCnt == tim.hLast;
    strb.lineAdv  = strb.lineEnd && (!tim.dblScan || scanRep);
    strb.frameEnd = strb.lineAdv && (vCnt == tim.vLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCnt    <= '0;
      vCnt    <= '0;
      scanRep <= 1'b0;
      field   <= 1'b0;
    end else begin
      hCnt <= strb.lineEnd ? '0 : hCnt + 1'b1;
      if (strb.lineEnd) scanRep <= !strb.lineAdv;
      if (strb.frameEnd) vCnt <= '0;
      else if (strb.lineAdv) vCnt <= vCnt + 1'b1;
      if (strb.frameEnd) field <= tim.interlace ? !field : 1'b0;
    end
  end

  // R4: the character counter restarts after the last character of a line
  p_line_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.lineEnd |=> hCnt == '0);

  // R4: counter never runs past the programmed line length
  p_hcnt_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    hCnt <= tim.hLast);

  // R10: interlaced fields alternate
  p_field_toggle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameEnd && tim.interlace) |=> field != $past(field));
endmodule

// File: rtl/crtc_dpath.sv
module crtc_dpath
  import crtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  crtc_timing_t      tim,
  input  crtc_strobe_t      strb,
  input  logic [HCNT_W-1:0] hCnt,
  input  logic [VCNT_W-1:0] vCnt,
  output logic              hSync,
  output logic              vSync,
  output logic              blank,
  output logic              dispEn
);
  logic hsFlag, vsFlag, hsAct, vsAct;
  logic hDe, vDe, vBlank;
  logic [VFLD_W-1:0] vDeEff;

  always_comb begin
    vDeEff = tim.interlace ? (tim.vDeLast >> 1) : tim.vDeLast;
    hDe    = hCnt <= tim.hDeLast;
    vDe    = vCnt <= VCNT_W'(vDeEff);
    vBlank = vCnt > VCNT_W'(tim.vBlankAfter);
    hsAct  = (hCnt == HCNT_W'(tim.hSyncStart)) ||
             (hsFlag && (hCnt[HSE_W-1:0] != tim.hSyncEnd));
    vsAct  = (vCnt == VCNT_W'(tim.vSyncStart)) ||
             (vsFlag && (vCnt[VSE_W-1:0] != tim.vSyncEnd));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsFlag <= 1'b0;
      vsFlag <= 1'b0;
    end else begin
      hsFlag <= hsAct;
      if (strb.lineAdv) vsFlag <= vsAct;
    end
  end

  assign hSync  = hsAct ^ tim.hNeg;
  assign vSync  = vsAct ^ tim.vNeg;
  assign blank  = !hDe || vBlank;
  assign dispEn = hDe && vDe;

  // R5: the sync-start character always shows the active level
  p_hsync_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hCnt == HCNT_W'(tim.hSyncStart)) |-> (hSync != tim.hNeg));

  // R8: vertical sync level only moves at a line advance
  p_vsync_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lineAdv |=> $stable(vsAct));
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import crtc_pkg::*;
#(
  parameter int REG_IDX_W = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        idxWr,
  input  logic        dataWr,
  input  logic        miscWr,
  input  logic [7:0]  wrByte,
  output logic        hSync,
  output logic        vSync,
  output logic        blank,
  output logic        dispEn,
  output logic        field
);
  crtc_timing_t      tim;
  crtc_strobe_t      strb;
  logic [HCNT_W-1:0] hCnt;
  logic [VCNT_W-1:0] vCnt;

  crtc_regfile #(.REG_IDX_W(REG_IDX_W)) regs_i (
    .clk(clk), .rstN(rstN), .idxWr(idxWr), .dataWr(dataWr), .miscWr(miscWr),
    .wrByte(wrByte), .strb(strb), .tim(tim)
  );

  crtc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .tim(tim), .strb(strb),
    .hCnt(hCnt), .vCnt(vCnt), .field(field)
  );

  crtc_dpath dpath_i (
    .clk(clk), .rstN(rstN), .tim(tim), .strb(strb), .hCnt(hCnt), .vCnt(vCnt),
    .hSync(hSync), .vSync(vSync), .blank(blank), .dispEn(dispEn)
  );
endmodule

// File: tb/crtc_timing_gen_tb_top.sv
module crtc_timing_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idxWr = 1'b0, dataWr = 1'b0, miscWr = 1'b0;
  logic [7:0] wrByte = '0;
  logic hSync, vSync, blank, dispEn, field;

  int checks = 0;
  int fails = 0;
  string phaseTag = "R12";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crtc_timing_gen dut_i (
    .clk(clk), .rstN(rstN), .idxWr(idxWr), .dataWr(dataWr), .miscWr(miscWr),
    .wrByte(wrByte), .hSync(hSync), .vSync(vSync), .blank(blank),
    .dispEn(dispEn), .field(field)
  );

  typedef struct {
    int hLast, hDe, hss, hse, vLast, vDe, vbs, vss, vse;
    bit dbl, il, hNeg, vNeg;
  } model_t;

  typedef struct packed { logic hs, vs, bl, de, fd; } exp_t;

  exp_t expQ[$];
  model_t act;
  logic [7:0] live [64];
  logic [7:0] mMisc, mIdx;
  int mh, mv;
  bit mRep, mField, mHsF, mVsF;
  bit le, la, fe, hsA, vsA;

  // Decode from the requirement text (R4..R11 field layout).
  function automatic model_t decode(input logic [7:0] r [64], input logic [7:0] m);
    model_t t;
    t.hLast = int'(r['h00]) + 4;
    t.hDe   = int'(r['h01]);
    t.hss   = int'(r['h04]);
    t.hse   = int'(r['h05] & 8'h1f);
    t.vLast = int'(r['h06]) + (r['h07][0] ? 256 : 0) + (r['h07][5] ? 512 : 0)
            + (r['h30][3] ? 1024 : 0) + 1;
    t.vDe   = int'(r['h12]) + (r['h07][1] ? 256 : 0) + (r['h07][6] ? 512 : 0)
            + (r['h30][2] ? 1024 : 0);
    t.vbs   = int'(r['h15]) + (r['h07][3] ? 256 : 0) + (r['h09][5] ? 512 : 0)
            + (r['h30][1] ? 1024 : 0);
    t.vss   = int'(r['h10]) + (r['h07][2] ? 256 : 0) + (r['h07][7] ? 512 : 0)
            + (r['h30][0] ? 1024 : 0);
    t.vse   = int'(r['h11] & 8'h0f);
    t.dbl   = r['h09][7];
    t.il    = r['h30][7];
    t.hNeg  = m[6];
    t.vNeg  = m[7];
    return t;
  endfunction

  function automatic bit hsNow();
    return (mh == act.hss) || (mHsF && ((mh % 32) != act.hse));
  endfunction

  function automatic bit vsNow();
    return (mv == act.vss) || (mVsF && ((mv % 16) != act.vse));
  endfunction

  function automatic exp_t expNow();
    exp_t e;
    int vdeEff;
    bit hDe, vDe;
    vdeEff = act.il ? act.vDe / 2 : act.vDe;
    hDe = mh <= act.hDe;
    vDe = mv <= vdeEff;
    e.hs = hsNow() ^ act.hNeg;
    e.vs = vsNow() ^ act.vNeg;
    e.bl = !hDe || (mv > act.vbs);
    e.de = hDe && vDe;
    e.fd = mField;
    return e;
  endfunction

  // Reference model: same edge ordering as the requirements (R3 reload uses pre-edge bank).
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) live[i] = '0;
      mMisc = '0; mIdx = '0;
      act = decode(live, mMisc);
      mh = 0; mv = 0; mRep = 0; mField = 0; mHsF = 0; mVsF = 0;
      expQ.delete();
    end else begin
      le  = (mh == act.hLast);
      la  = le && (!act.dbl || mRep);
      fe  = la && (mv == act.vLast);
      hsA = hsNow();
      vsA = vsNow();
      mHsF = hsA;
      if (la) mVsF = vsA;
      if (le) mRep = !la;
      mh = le ? 0 : mh + 1;
      if (fe) mv = 0; else if (la) mv = mv + 1;
      if (fe) mField = act.il ? !mField : 1'b0;
      if (fe) act = decode(live, mMisc);
      if (dataWr && mIdx < 64 && !(live['h11][7] && mIdx < 8)) live[mIdx[5:0]] = wrByte;
      if (idxWr) mIdx = wrByte;
      if (miscWr) mMisc = wrByte;
      expQ.push_back(expNow());
    end
  end

  // Monitor: pop one expected item per cycle and compare away from the edge.
  always @(negedge clk) begin
    exp_t e;
    if (rstN && !done && expQ.size() > 0) begin
      e = expQ.pop_front();
      checks++;
      if ({hSync, vSync, blank, dispEn, field} !== e) begin
        fails++;
        $display("FAIL %s: {hSync,vSync,blank,dispEn,field} actual %b%b%b%b%b expected %b%b%b%b%b at %0t",
                 phaseTag, hSync, vSync, blank, dispEn, field,
                 e.hs, e.vs, e.bl, e.de, e.fd, $time);
      end
    end
  end

  task automatic writeReg(input int idx, input int val);
    @(negedge clk); idxWr = 1'b1; wrByte = 8'(idx);
    @(negedge clk); idxWr = 1'b0; dataWr = 1'b1; wrByte = 8'(val);
    @(negedge clk); dataWr = 1'b0;
  endtask

  task automatic writeMisc(input int val);
    @(negedge clk); miscWr = 1'b1; wrByte = 8'(val);
    @(negedge clk); miscWr = 1'b0;
  endtask

  task automatic setVert(input int vtot, vde, vbs, vss, vse, input bit dbl, il, lock);
    logic [10:0] t, d, b, s;
    t = 11'(vtot); d = 11'(vde); b = 11'(vbs); s = 11'(vss);
    writeReg('h06, t[7:0]);
    writeReg('h12, d[7:0]);
    writeReg('h15, b[7:0]);
    writeReg('h10, s[7:0]);
    writeReg('h07, {s[9], d[9], t[9], 1'b0, b[8], s[8], d[8], t[8]});
    writeReg('h09, {dbl, 1'b0, b[9], 5'd0});
    writeReg('h30, {il, 3'd0, t[10], d[10], b[10], s[10]});
    writeReg('h11, {lock, 3'd0, 4'(vse)});
  endtask

  task automatic setHoriz(input int htot, hde, hss, hse);
    writeReg('h00, htot);
    writeReg('h01, hde);
    writeReg('h04, hss);
    writeReg('h05, hse);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12: first character after reset
    checks++;
    if ({hSync, vSync, blank, dispEn, field} !== 5'b11010) begin
      fails++;
      $display("FAIL R12: reset outputs actual %b%b%b%b%b expected 11010",
               hSync, vSync, blank, dispEn, field);
    end
    waitCycles(20);

    phaseTag = "R1/R3/R4/R5/R7/R8";
    setHoriz(11, 9, 11, 14);
    setVert(8, 6, 7, 8, 9, 1'b0, 1'b0, 1'b0);
    waitCycles(500);

    phaseTag = "R11";
    writeMisc('hC0);
    waitCycles(400);
    writeMisc('h40);
    waitCycles(400);

    phaseTag = "R2";
    writeReg('h11, 'h89);
    writeReg('h00, 20);
    writeReg('h06, 3);
    writeReg('h12, 4);
    waitCycles(500);
    writeReg('h11, 'h09);
    writeReg('h00, 7);
    waitCycles(400);

    phaseTag = "R9";
    setVert(8, 6, 7, 8, 9, 1'b1, 1'b0, 1'b0);
    waitCycles(800);

    phaseTag = "R10";
    setVert(8, 6, 7, 5, 7, 1'b0, 1'b1, 1'b0);
    waitCycles(700);
    setVert(8, 6, 7, 5, 7, 1'b0, 1'b0, 1'b0);
    waitCycles(400);

    phaseTag = "R6/R5";
    writeMisc('h00);
    setHoriz(1, 3, 3, 2);
    setVert('h5F0, 'h2A0, 'h3B0, 'h5C0, 3, 1'b0, 1'b0, 1'b0);
    waitCycles(22000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule